// File: doc/BRIEF.md
# Receiver Reset Launcher After Configuration

This block drives the user-side steps that put a serial receiver through a full reset right after the device has finished configuring. Once the configuration-complete input is seen high, it waits a guard time. If the receiver's reset logic came up in single-step mode, it then moves the mode select to sequential and waits a settle time. Next it raises the master receive reset together with a PLL reset pulse of fixed width. The master reset stays high for the whole pulse and afterwards.

With the master reset still held, the block reads one word of the receiver's configuration port at a fixed address and writes it back with one bit cleared. It then waits for PLL lock and releases the master reset. When the receiver reports reset-done, it writes the saved word back so the bit regains its original value, and then raises its own done output. Each configuration-port access is a single-cycle enable strobe followed by a wait for the ready strobe.

The sequencer has thirteen states. The normal path is:
- IDLE -> GUARD when configuration is complete.
- GUARD -> MODE_SETTLE when the guard time expires in single-step mode, or GUARD -> PLL_PULSE when it expires in sequential mode.
- MODE_SETTLE -> PLL_PULSE when the settle time expires.
- PLL_PULSE -> RD_REQ when the pulse time expires.
- RD_REQ -> RD_WAIT.
- RD_WAIT -> CLR_REQ on ready.
- CLR_REQ -> CLR_WAIT.
- CLR_WAIT -> LOCK_WAIT on ready.
- LOCK_WAIT -> RDONE_WAIT on lock.
- RDONE_WAIT -> RST_REQ on reset-done.
- RST_REQ -> RST_WAIT.
- RST_WAIT -> FINISHED on ready.

FINISHED is terminal until the next reset. Wait times are clock-cycle counts derived from a clock-frequency parameter and rounded up.

Top module: `rx_cfg_reset_seq`

## Requirements
- R1: Out of reset, pll_rst, rx_master_rst, cp_en and seq_done are low, and reset_mode_sel equals boot_single_mode (1 = single-step mode, 0 = sequential).
- R2: While cfg_done is low, the block does nothing. After cfg_done is sampled high, pll_rst and rx_master_rst rise no earlier than 500 ns after cfg_done rose. In sequential mode, they rise within one clock period after that minimum.
- R3: When boot_single_mode is 1, reset_mode_sel falls to 0 no earlier than 500 ns after cfg_done rose (and within one clock period after that minimum). pll_rst then rises between 300 ns and 500 ns after that fall. pll_rst is never high while reset_mode_sel is 1.
- R4: rx_master_rst rises in the same cycle as pll_rst. pll_rst stays high for exactly PLL_PULSE_CYC cycles, and rx_master_rst stays high throughout the pulse and after it.
- R5: After the pulse, the block reads address 0x011 (cp_we low).
- R6: After the read completes, the block writes address 0x011 with the word it read, bit 11 forced to 0. This happens while rx_master_rst is still high.
- R7: cp_en is a one-cycle strobe. No new cp_en is issued until cp_rdy has answered the previous access.
- R8: rx_master_rst stays high until pll_locked is sampled high after the clearing write has completed, and it falls in the cycle after that sample.
- R9: Only after rx_master_rst has fallen and rx_rst_done is high does the block write the originally read word back to address 0x011. This restores bit 11.
- R10: seq_done is low until the restoring write has been answered. After that it follows rx_rst_done.
- R11: The procedure runs once per reset. Later changes on cfg_done start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_done | input | 1 | Device configuration complete |
| boot_single_mode | input | 1 | Reset mode the receiver powered up in (1 = single-step) |
| reset_mode_sel | output | 1 | Receiver reset mode select (1 = single-step, 0 = sequential) |
| pll_rst | output | 1 | PLL reset pulse |
| pll_locked | input | 1 | PLL lock indication |
| rx_master_rst | output | 1 | Master receive reset |
| rx_rst_done | input | 1 | Receiver reset-done indication |
| cp_addr | output | 9 | Configuration-port address |
| cp_wdata | output | 16 | Configuration-port write data |
| cp_rdata | input | 16 | Configuration-port read data |
| cp_en | output | 1 | Configuration-port access strobe |
| cp_we | output | 1 | Configuration-port write select (qualified by cp_en) |
| cp_rdy | input | 1 | Configuration-port access complete |
| seq_done | output | 1 | Procedure finished and receiver out of reset |

## Verification
A sequencer stuck in or skipping a wait state shows up within one clock as a misplaced rising or falling edge on pll_rst or rx_master_rst. The bench measures those edges against cfg_done in whole cycles. A wrong saved word or a lost ready wait appears at the configuration port on the very next strobe: a wrong data value, a strobe issued early, or a strobe issued with no request pending, which the scoreboard of expected accesses flags. A terminal state reached too early or too late is caught by seq_done rising before the restoring write or failing to rise after it.

// File: rtl/rxcr_pkg.sv
package rxcr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GUARD,
        ST_MODE_SETTLE,
        ST_PLL_PULSE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_CLR_REQ,
        ST_CLR_WAIT,
        ST_LOCK_WAIT,
        ST_RDONE_WAIT,
        ST_RST_REQ,
        ST_RST_WAIT,
        ST_FINISHED
    } seq_state_e;

    // Convert a time in ns to clock cycles, rounding up, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rxcr_wait_timer.sv
module rxcr_wait_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/rxcr_cfg_port.sv
module rxcr_cfg_port #(
    parameter int unsigned    AW   = 9,
    parameter int unsigned    DW   = 16,
    parameter logic [AW-1:0]  ADDR = 9'h011
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic [DW-1:0] req_wdata,
    output logic [AW-1:0] cp_addr,
    output logic [DW-1:0] cp_wdata,
    output logic          cp_en,
    output logic          cp_we,
    input  logic          cp_rdy,
    input  logic [DW-1:0] cp_rdata,
    output logic          ack,
    output logic [DW-1:0] ack_data,
    output logic          busy
);

    logic          en_q;
    logic          busy_q;
    logic          we_q;
    logic [DW-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            busy_q  <= 1'b0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            en_q <= 1'b0;
            if (req && !busy_q) begin
                en_q    <= 1'b1;
                busy_q  <= 1'b1;
                we_q    <= req_we;
                wdata_q <= req_wdata;
            end else if (busy_q && cp_rdy) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign cp_addr  = ADDR;
    assign cp_wdata = wdata_q;
    assign cp_en    = en_q;
    assign cp_we    = we_q & en_q;
    assign ack      = busy_q & cp_rdy;
    assign ack_data = cp_rdata;
    assign busy     = busy_q;

endmodule

// File: rtl/rx_cfg_reset_seq.sv
module rx_cfg_reset_seq #(
    parameter int unsigned   CLK_MHZ       = 100,
    parameter int unsigned   GUARD_NS      = 500,
    parameter int unsigned   SETTLE_NS     = 400,
    parameter int unsigned   PLL_PULSE_CYC = 4,
    parameter int unsigned   AW            = 9,
    parameter int unsigned   DW            = 16,
    parameter logic [AW-1:0] REG_ADDR      = 9'h011,
    parameter int unsigned   BIT_IDX       = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_done,
    input  logic          boot_single_mode,
    output logic          reset_mode_sel,
    output logic          pll_rst,
    input  logic          pll_locked,
    output logic          rx_master_rst,
    input  logic          rx_rst_done,
    output logic [AW-1:0] cp_addr,
    output logic [DW-1:0] cp_wdata,
    input  logic [DW-1:0] cp_rdata,
    output logic          cp_en,
    output logic          cp_we,
    input  logic          cp_rdy,
    output logic          seq_done
);
    import rxcr_pkg::*;

    localparam int unsigned GUARD_CYC  = ns_to_cycles(GUARD_NS, CLK_MHZ);
    localparam int unsigned SETTLE_CYC = ns_to_cycles(SETTLE_NS, CLK_MHZ);
    localparam int unsigned PULSE_CYC  = (PLL_PULSE_CYC == 0) ? 1 : PLL_PULSE_CYC;
    localparam int unsigned MAX_CYC    = max3(GUARD_CYC, SETTLE_CYC, PULSE_CYC);
    localparam int unsigned TW         = $clog2(MAX_CYC + 1);
    localparam logic [DW-1:0] BIT_MASK = DW'(1) << BIT_IDX;

    seq_state_e    state_q, state_d;
    logic [DW-1:0] saved_q;
    logic          switched_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;

    logic          req, req_we;
    logic [DW-1:0] req_wdata;
    logic          ack;
    logic [DW-1:0] ack_data;
    logic          cp_busy;

    rxcr_wait_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    rxcr_cfg_port #(.AW(AW), .DW(DW), .ADDR(REG_ADDR)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .cp_addr   (cp_addr),
        .cp_wdata  (cp_wdata),
        .cp_en     (cp_en),
        .cp_we     (cp_we),
        .cp_rdy    (cp_rdy),
        .cp_rdata  (cp_rdata),
        .ack       (ack),
        .ack_data  (ack_data),
        .busy      (cp_busy)
    );

    // State register with the two pieces of state the sequence carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            saved_q    <= '0;
            switched_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RD_WAIT && ack) begin
                saved_q <= ack_data;
            end
            if (state_q == ST_GUARD && tmr_exp && boot_single_mode) begin
                switched_q <= 1'b1;
            end
        end
    end

    // Next state and timer loading.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_done) begin
                    state_d  = ST_GUARD;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(GUARD_CYC - 1);
                end
            end
            ST_GUARD: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (boot_single_mode) begin
                        state_d = ST_MODE_SETTLE;
                        tmr_val = TW'(SETTLE_CYC - 1);
                    end else begin
                        state_d = ST_PLL_PULSE;
                        tmr_val = TW'(PULSE_CYC - 1);
                    end
                end
            end
            ST_MODE_SETTLE: begin
                if (tmr_exp) begin
                    state_d  = ST_PLL_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PULSE_CYC - 1);
                end
            end
            ST_PLL_PULSE:  if (tmr_exp)     state_d = ST_RD_REQ;
            ST_RD_REQ:                      state_d = ST_RD_WAIT;
            ST_RD_WAIT:    if (ack)         state_d = ST_CLR_REQ;
            ST_CLR_REQ:                     state_d = ST_CLR_WAIT;
            ST_CLR_WAIT:   if (ack)         state_d = ST_LOCK_WAIT;
            ST_LOCK_WAIT:  if (pll_locked)  state_d = ST_RDONE_WAIT;
            ST_RDONE_WAIT: if (rx_rst_done) state_d = ST_RST_REQ;
            ST_RST_REQ:                     state_d = ST_RST_WAIT;
            ST_RST_WAIT:   if (ack)         state_d = ST_FINISHED;
            ST_FINISHED:                    state_d = ST_FINISHED;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state.
    always_comb begin
        pll_rst        = 1'b0;
        rx_master_rst  = 1'b0;
        req            = 1'b0;
        req_we         = 1'b0;
        req_wdata      = saved_q;
        seq_done       = 1'b0;
        reset_mode_sel = boot_single_mode & ~switched_q;
        unique case (state_q)
            ST_PLL_PULSE: begin
                pll_rst       = 1'b1;
                rx_master_rst = 1'b1;
            end
            ST_RD_REQ: begin
                rx_master_rst = 1'b1;
                req           = 1'b1;
            end
            ST_CLR_REQ: begin
                rx_master_rst = 1'b1;
                req           = 1'b1;
                req_we        = 1'b1;
                req_wdata     = saved_q & ~BIT_MASK;
            end
            ST_RD_WAIT, ST_CLR_WAIT, ST_LOCK_WAIT: begin
                rx_master_rst = 1'b1;
            end
            ST_RST_REQ: begin
                req    = 1'b1;
                req_we = 1'b1;
            end
            ST_FINISHED: begin
                seq_done = rx_rst_done;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/rx_cfg_reset_seq_chk.sv
module rx_cfg_reset_seq_chk #(
    parameter int unsigned DW      = 16,
    parameter int unsigned BIT_IDX = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pll_rst,
    input logic          rx_master_rst,
    input logic          pll_locked,
    input logic          cp_en,
    input logic          cp_we,
    input logic [DW-1:0] cp_wdata,
    input logic          reset_mode_sel,
    input logic          seq_done,
    input logic          cp_busy
);

    p_pulse_in_master_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst |-> rx_master_rst);

    p_master_rise_with_pll_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_master_rst) |-> pll_rst);

    p_en_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cp_en |=> !cp_en);

    p_no_en_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_busy && !cp_en) |=> !cp_en);

    p_release_after_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_master_rst) |-> $past(pll_locked));

    p_clear_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_en && cp_we && rx_master_rst) |-> !cp_wdata[BIT_IDX]);

    p_seq_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst |-> !reset_mode_sel);

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (!rx_master_rst && !pll_rst && !cp_busy));

endmodule

bind rx_cfg_reset_seq rx_cfg_reset_seq_chk #(.DW(DW), .BIT_IDX(BIT_IDX)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pll_rst        (pll_rst),
    .rx_master_rst  (rx_master_rst),
    .pll_locked     (pll_locked),
    .cp_en          (cp_en),
    .cp_we          (cp_we),
    .cp_wdata       (cp_wdata),
    .reset_mode_sel (reset_mode_sel),
    .seq_done       (seq_done),
    .cp_busy        (cp_busy)
);

// File: tb/rx_cfg_reset_seq_bench.sv
module rx_cfg_reset_seq_bench;

    typedef struct packed {
        logic        we;
        logic [8:0]  addr;
        logic [15:0] data;
    } txn_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_done = 1'b0;
    logic        boot_single_mode = 1'b0;
    logic        reset_mode_sel;
    logic        pll_rst;
    logic        pll_locked = 1'b0;
    logic        rx_master_rst;
    logic        rx_rst_done = 1'b0;
    logic [8:0]  cp_addr;
    logic [15:0] cp_wdata;
    logic [15:0] cp_rdata = '0;
    logic        cp_en;
    logic        cp_we;
    logic        cp_rdy = 1'b0;
    logic        seq_done;

    int          total = 0;
    int          bad = 0;
    int          cyc = 0;
    txn_t        exp_q[$];
    logic [15:0] mem = '0;
    int          lat_g = 1;
    int          pend = 0;
    logic        pend_we = 1'b0;
    logic [15:0] pend_wd = '0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rx_cfg_reset_seq u_rx_cfg_reset_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_done         (cfg_done),
        .boot_single_mode (boot_single_mode),
        .reset_mode_sel   (reset_mode_sel),
        .pll_rst          (pll_rst),
        .pll_locked       (pll_locked),
        .rx_master_rst    (rx_master_rst),
        .rx_rst_done      (rx_rst_done),
        .cp_addr          (cp_addr),
        .cp_wdata         (cp_wdata),
        .cp_rdata         (cp_rdata),
        .cp_en            (cp_en),
        .cp_we            (cp_we),
        .cp_rdy           (cp_rdy),
        .seq_done         (seq_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor: configuration-port responder and scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (cp_rdy) begin
                cp_rdy = 1'b0;
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    cp_rdy   = 1'b1;
                    cp_rdata = mem;
                    if (pend_we) mem = pend_wd;
                end
            end
            if (rst_n && cp_en) begin
                txn_t e;
                check(pend == 0, "R7", "strobe while access pending", pend, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected access", {cp_we, cp_wdata}, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(cp_addr == e.addr, "R5", "access address", cp_addr, e.addr);
                    check(cp_we == e.we, "R5", "access direction", cp_we, e.we);
                    if (e.we) begin
                        check(cp_wdata == e.data, "R6", "write data", cp_wdata, e.data);
                        if (!rx_master_rst)
                            check(rx_rst_done, "R9", "restore before reset-done", rx_rst_done, 1);
                    end
                end
                pend    = lat_g;
                pend_we = cp_we;
                pend_wd = cp_wdata;
            end
        end
    end

    // Driver: one full procedure.
    task automatic run_case(input bit single, input logic [15:0] regval, input int lat);
        int  t0, t_mode, t_pll, width, tl;
        bit  ok;
        boot_single_mode = single;
        cfg_done    = 1'b0;
        pll_locked  = 1'b0;
        rx_rst_done = 1'b0;
        mem   = regval;
        lat_g = lat;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pll_rst && !rx_master_rst && !cp_en && !seq_done, "R1", "outputs after reset",
              {pll_rst, rx_master_rst, cp_en, seq_done}, 0);
        check(reset_mode_sel == single, "R1", "mode select after reset", reset_mode_sel, single);

        exp_q.push_back('{we: 1'b0, addr: 9'h011, data: 16'h0});
        exp_q.push_back('{we: 1'b1, addr: 9'h011, data: regval & ~16'h0800});
        exp_q.push_back('{we: 1'b1, addr: 9'h011, data: regval});

        ok = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (pll_rst || rx_master_rst || cp_en) ok = 1'b0;
        end
        check(ok, "R2", "activity before cfg_done", !ok, 0);

        cfg_done = 1'b1;
        t0 = cyc;
        t_mode = -1;
        ok = 1'b1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!reset_mode_sel && t_mode < 0) t_mode = cyc;
            if (pll_rst) break;
            if (rx_master_rst) ok = 1'b0;
        end
        t_pll = cyc;
        check(ok, "R4", "master reset before pulse", !ok, 0);
        check(rx_master_rst, "R4", "master reset with pulse", rx_master_rst, 1);
        if (!single) begin
            check((t_pll - t0) * 10 - 5 >= 500 && (t_pll - t0) * 10 - 5 <= 510, "R2",
                  "guard delay ns", (t_pll - t0) * 10 - 5, 505);
        end else begin
            check(t_mode >= 0 && (t_mode - t0) * 10 - 5 >= 500 && (t_mode - t0) * 10 - 5 <= 510,
                  "R3", "mode switch delay ns", (t_mode - t0) * 10 - 5, 505);
            check((t_pll - t_mode) * 10 >= 300 && (t_pll - t_mode) * 10 <= 500, "R3",
                  "settle delay ns", (t_pll - t_mode) * 10, 400);
        end

        width = 0;
        ok = 1'b1;
        while (pll_rst && width < 100) begin
            if (!rx_master_rst) ok = 1'b0;
            width++;
            @(negedge clk);
        end
        check(width == 4, "R4", "pulse width", width, 4);
        check(ok && rx_master_rst, "R4", "master held over pulse", rx_master_rst, 1);

        ok = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (!rx_master_rst) ok = 1'b0;
        end
        check(ok, "R8", "master released without lock", !ok, 0);
        check(exp_q.size() == 1, "R6", "read and clear done", exp_q.size(), 1);
        check(mem[11] == 1'b0, "R6", "bit 11 cleared", mem[11], 0);

        pll_locked = 1'b1;
        tl = cyc;
        @(negedge clk);
        check(!rx_master_rst && cyc == tl + 1, "R8", "release one cycle after lock",
              rx_master_rst, 0);

        ok = 1'b1;
        repeat (15) begin
            @(negedge clk);
            if (cp_en || seq_done) ok = 1'b0;
        end
        check(ok && exp_q.size() == 1, "R9", "no restore before reset-done", exp_q.size(), 1);

        rx_rst_done = 1'b1;
        ok = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (seq_done) begin
                if (exp_q.size() != 0) ok = 1'b0;
                break;
            end
        end
        check(ok, "R10", "done before restore", exp_q.size(), 0);
        check(seq_done, "R10", "done after restore", seq_done, 1);
        check(mem == regval, "R9", "register restored", mem, regval);

        rx_rst_done = 1'b0;
        @(negedge clk);
        check(!seq_done, "R10", "done follows reset-done", seq_done, 0);
        rx_rst_done = 1'b1;
        @(negedge clk);

        cfg_done = 1'b0;
        repeat (10) @(negedge clk);
        cfg_done = 1'b1;
        ok = 1'b1;
        repeat (100) begin
            @(negedge clk);
            if (pll_rst || rx_master_rst || cp_en || !seq_done) ok = 1'b0;
        end
        check(ok, "R11", "no restart on cfg_done", !ok, 0);
    endtask

    initial begin
        run_case(1'b0, 16'hA85B, 1);
        run_case(1'b1, 16'h0123, 3);
        run_case(1'b1, 16'hFFFF, 5);
        run_case(1'b0, 16'h0800, 2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule